// File: doc/BRIEF.md
# Continuous successive-approximation conversion sequencer

This block is the digital half of an 8-bit successive-approximation converter. It runs one conversion after another without stopping. Each conversion starts with a sample/hold strobe. Then, over one clock per bit and starting at the most significant bit, the block drives a trial code to an external resistor-ladder decoder. It reads back a single comparator bit and keeps or drops the trial bit. When the least significant bit has been decided, the finished code is copied into a result register and the next conversion begins at once on the same input.

A select command picks one of two analog inputs. The channel number goes out on a channel output to the external multiplexer. The select also throws away the conversion in progress and starts again with a fresh sample. The result register keeps the last finished code until a new conversion completes. A read command copies the result register, never the working register, onto the read data output.

Top module: `sar_seq`

## Requirements
- R1: While reset is held and in the first cycle after its release, sh_strobe is 1, trial_code is 0, ch_sel is 0, done is 0 and rd_data is 0. The result register is cleared to 0.
- R2: Each conversion lasts WIDTH+1 cycles: one sample cycle with trial_code 0, then WIDTH trial cycles. In trial cycle k (k = 1..WIDTH) the trial code is the bits already decided OR'd with bit WIDTH-k set.
- R3: A comparator input cmp_hi of 1 (input at or above the tap) keeps the bit under trial, and 0 clears it. With an ideal comparator the finished code equals the input value, including 0 and 255.
- R4: After the last trial cycle, the finished code is written to the result register and done is 1 for exactly the following cycle.
- R5: Conversion is continuous: the cycle after the last trial cycle is again a sample cycle (sh_strobe 1), with no command needed.
- R6: A cycle with sel_valid 1 makes ch_sel equal to that cycle's sel_ch from the next cycle, and the next cycle is a sample cycle.
- R7: A select during a conversion discards the partial code, and the result register keeps the previous finished code.
- R8: A select in the last trial cycle takes priority: the result register is not written and done stays 0.
- R9: A cycle with rd_en 1 makes rd_data equal to the result register's value in that cycle, from the next cycle on. rd_data holds its value otherwise.
- R10: Without a select, ch_sel does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | Select command: choose a channel and restart |
| sel_ch | input | 1 | Channel chosen by the select command |
| cmp_hi | input | 1 | Comparator result, 1 when the input is at or above the tap |
| rd_en | input | 1 | Read command for the result register |
| trial_code | output | WIDTH | Code to the resistor-ladder decoder |
| sh_strobe | output | 1 | Sample/hold strobe, high in the sample cycle |
| ch_sel | output | 1 | Channel number to the analog multiplexer |
| done | output | 1 | One-cycle pulse after a result update |
| rd_data | output | WIDTH | Result register contents captured by the last read |

## Verification
The bench drives inputs at codes 0 and 255, where a comparison made the wrong way round or an off-by-one bit index would show up as a code one step wrong or stuck at one end. It issues a select partway through a conversion and then reads at once. A design that reset the result register, or latched the partial working code, would return the wrong value. It also issues a select exactly in the last trial cycle. A design that let the finishing conversion win would pulse done and overwrite the result. Throughout the run, a per-cycle model checks the strobe spacing, the order of the trial codes and the channel output, so a stalled or skipped step shows up in the first cycle it happens.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Step kind of the sequencer in the current cycle
  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_TRIAL  = 2'd1,
    PH_LAST   = 2'd2
  } phase_e;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      restart,
  output phase_e                    phase,
  output logic [$clog2(WIDTH)-1:0]  bit_idx
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam int IW = $clog2(WIDTH);

  logic [CW-1:0] step_q;
  logic [CW-1:0] remain;

  // step_q: 0 = sample cycle, 1..WIDTH = trial cycles, MSB first
  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      step_q <= '0;
    end else if (step_q == CW'(WIDTH)) begin
      step_q <= '0;
    end else begin
      step_q <= step_q + 1'b1;
    end
  end

  assign remain  = CW'(WIDTH) - step_q;
  assign bit_idx = remain[IW-1:0];

  always_comb begin
    if (step_q == '0) begin
      phase = PH_SAMPLE;
    end else if (step_q == CW'(WIDTH)) begin
      phase = PH_LAST;
    end else begin
      phase = PH_TRIAL;
    end
  end
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      restart,
  input  phase_e                    phase,
  input  logic [$clog2(WIDTH)-1:0]  bit_idx,
  input  logic                      cmp_hi,
  output logic [WIDTH-1:0]          trial_code,
  output logic [WIDTH-1:0]          final_code
);
  localparam int IW = $clog2(WIDTH);

  logic [WIDTH-1:0] sar_q;
  logic [WIDTH-1:0] decided;

  // Set the bit under test on top of the bits already decided
  function automatic logic [WIDTH-1:0] with_trial(input logic [WIDTH-1:0] code,
                                                  input logic [IW-1:0] idx);
    logic [WIDTH-1:0] mask;
    mask = '0;
    mask[idx] = 1'b1;
    return code | mask;
  endfunction

  // Keep or drop the bit under test according to the comparator
  function automatic logic [WIDTH-1:0] decide(input logic [WIDTH-1:0] code,
                                              input logic [IW-1:0] idx,
                                              input logic keep);
    logic [WIDTH-1:0] mask;
    mask = '0;
    mask[idx] = 1'b1;
    return keep ? (code | mask) : (code & ~mask);
  endfunction

  assign decided    = decide(sar_q, bit_idx, cmp_hi);
  assign final_code = decided;
  assign trial_code = (phase == PH_SAMPLE) ? '0 : with_trial(sar_q, bit_idx);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || phase == PH_SAMPLE) begin
      sar_q <= '0;
    end else begin
      sar_q <= decided;
    end
  end
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [WIDTH-1:0] final_code,
  input  logic             rd_en,
  output logic [WIDTH-1:0] result_q,
  output logic             done,
  output logic [WIDTH-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      done     <= 1'b0;
      rd_data  <= '0;
    end else begin
      done <= commit;
      if (commit) begin
        result_q <= final_code;
      end
      if (rd_en) begin
        rd_data <= result_q;
      end
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_valid,
  input  logic             sel_ch,
  input  logic             cmp_hi,
  input  logic             rd_en,
  output logic [WIDTH-1:0] trial_code,
  output logic             sh_strobe,
  output logic             ch_sel,
  output logic             done,
  output logic [WIDTH-1:0] rd_data
);
  localparam int IW = $clog2(WIDTH);

  phase_e           phase;
  logic [IW-1:0]    bit_idx;
  logic [WIDTH-1:0] final_code;
  logic [WIDTH-1:0] result_q;
  logic             restart;
  logic             commit;

  // Named internal events
  assign restart = sel_valid;
  assign commit  = (phase == PH_LAST) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_sel <= 1'b0;
    end else if (sel_valid) begin
      ch_sel <= sel_ch;
    end
  end

  sar_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .phase   (phase),
    .bit_idx (bit_idx)
  );

  sar_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .phase      (phase),
    .bit_idx    (bit_idx),
    .cmp_hi     (cmp_hi),
    .trial_code (trial_code),
    .final_code (final_code)
  );

  sar_result #(.WIDTH(WIDTH)) res_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .final_code (final_code),
    .rd_en      (rd_en),
    .result_q   (result_q),
    .done       (done),
    .rd_data    (rd_data)
  );

  assign sh_strobe = (phase == PH_SAMPLE);
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_valid,
  input logic             sel_ch,
  input logic             sh_strobe,
  input logic [WIDTH-1:0] trial_code,
  input logic             ch_sel,
  input logic             done,
  input logic             commit,
  input logic [WIDTH-1:0] result_q
);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  // R2: first trial after a sample is the MSB alone
  p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_strobe && !sel_valid) |=> (trial_code == MSB_ONLY));

  // R2: a sample cycle lasts one cycle unless restarted
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_strobe && !sel_valid) |=> !sh_strobe);

  // R4: done is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4, R5: a commit is followed by done and a fresh sample
  p_commit_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (done && sh_strobe));

  // R6: select restarts with a sample on the chosen channel
  p_select_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> (sh_strobe && ch_sel == $past(sel_ch)));

  // R7: result register only changes on a commit
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(result_q));

  // R8: a select wins over the final comparison
  p_select_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> !done);

  // R10: channel is stable without a select
  p_ch_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |=> $stable(ch_sel));
endmodule

bind sar_seq sar_seq_chk #(.WIDTH(WIDTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_valid  (sel_valid),
  .sel_ch     (sel_ch),
  .sh_strobe  (sh_strobe),
  .trial_code (trial_code),
  .ch_sel     (ch_sel),
  .done       (done),
  .commit     (commit),
  .result_q   (result_q)
);

// File: tb/sar_seq_tb_top.sv
module sar_seq_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, sel_valid, sel_ch, cmp_hi, rd_en;
  logic [W-1:0] trial_code, rd_data;
  logic         sh_strobe, ch_sel, done;
  logic [W-1:0] vin [2];

  sar_seq #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_ch(sel_ch),
    .cmp_hi(cmp_hi), .rd_en(rd_en), .trial_code(trial_code),
    .sh_strobe(sh_strobe), .ch_sel(ch_sel), .done(done), .rd_data(rd_data)
  );

  // Ideal analog comparator
  assign cmp_hi = (vin[ch_sel] >= trial_code);

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 0;

  // Behavioural reference state
  int m_step, m_sar, m_res, m_ch, m_done, m_rd;

  function automatic int m_trial();
    if (m_step == 0) return 0;
    return m_sar | (1 << (W - m_step));
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2", "trial_code", int'(trial_code), m_trial());
    check("R5", "sh_strobe", int'(sh_strobe), (m_step == 0) ? 1 : 0);
    check("R6", "ch_sel", int'(ch_sel), m_ch);
    check("R4", "done", int'(done), m_done);
    check("R9", "rd_data", int'(rd_data), m_rd);
  endtask

  task automatic step(input bit sv, input bit sc, input bit rd);
    int n_step, n_sar, n_res, n_ch, n_done, n_rd, t;
    sel_valid = sv; sel_ch = sc; rd_en = rd;
    n_step = m_step; n_sar = m_sar; n_res = m_res; n_ch = m_ch;
    n_done = 0; n_rd = rd ? m_res : m_rd;
    if (sv) begin
      n_ch = sc; n_step = 0; n_sar = 0;
    end else if (m_step == 0) begin
      n_step = 1; n_sar = 0;
    end else begin
      t = m_trial();
      if (int'(vin[m_ch]) >= t) n_sar = t;
      if (m_step == W) begin
        n_res = n_sar; n_done = 1; n_step = 0;
      end else begin
        n_step = m_step + 1;
      end
    end
    @(negedge clk);
    m_step = n_step; m_sar = n_sar; m_res = n_res; m_ch = n_ch;
    m_done = n_done; m_rd = n_rd;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic wait_step(input int s);
    while (m_step != s) step(0, 0, 0);
  endtask

  task automatic read_check(input string req, input int exp);
    step(0, 0, 1);
    check(req, "read result", int'(rd_data), exp);
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  initial begin
    #400000;
    if (!reported) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; sel_valid = 0; sel_ch = 0; rd_en = 0;
    vin[0] = 8'hA5; vin[1] = 8'h3C;
    m_step = 0; m_sar = 0; m_res = 0; m_ch = 0; m_done = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: state right after reset release
    check("R1", "sh_strobe", int'(sh_strobe), 1);
    check("R1", "trial_code", int'(trial_code), 0);
    check("R1", "ch_sel", int'(ch_sel), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "rd_data", int'(rd_data), 0);

    // R3/R4: conversion of channel 0
    idle(W + 1);
    check("R4", "done after conversion", int'(done), 1);
    read_check("R3", 8'hA5);
    // R5: continues without a command
    wait_step(0);
    idle(2 * (W + 1));
    read_check("R5", 8'hA5);

    // R3: extremes
    vin[0] = 8'h00;
    wait_step(0); idle(W + 1);
    read_check("R3", 0);
    vin[0] = 8'hFF;
    wait_step(0); idle(W + 1);
    read_check("R3", 255);
    check("R10", "ch_sel held", int'(ch_sel), 0);

    // R7: select mid conversion keeps previous result
    wait_step(4);
    step(1, 1, 0);
    check("R6", "strobe after select", int'(sh_strobe), 1);
    check("R6", "ch_sel after select", int'(ch_sel), 1);
    read_check("R7", 255);
    idle(W);
    read_check("R4", 8'h3C);

    // R8: select in the last trial cycle
    wait_step(W);
    step(1, 0, 0);
    check("R8", "done suppressed", int'(done), 0);
    read_check("R8", 8'h3C);
    idle(W);
    read_check("R4", 255);

    // R9: rd_data holds without a read
    vin[0] = 8'h5A;
    idle(3 * (W + 1));
    check("R9", "rd_data held", int'(rd_data), 255);
    read_check("R9", 8'h5A);

    summary();
    $finish;
  end
endmodule